// File: doc/BRIEF.md
# Raster Logic-Operation Merge Unit

This unit sits in the output-merger stage of a pixel pipeline. For every pixel it receives the colour from the fragment stage (source), the colour currently stored in the framebuffer (destination), the result an alpha-blend unit already produced for that pixel, and the pixel's coordinates. When blending is switched off, it replaces the blend result with one of sixteen bitwise combinations of source and destination. The same operation is applied to each 8-bit channel of the RGBA word on its own. When blending is on, the blend result passes through unchanged.

Two configuration registers are written through a small write port. One register selects the bitwise operation. The other turns blending on or off. Pixels move on a valid/ready stream. There is one register stage between input and output, and a stalled output holds back the input through the ready signal. The coordinates travel with the colour unchanged.

Top module: `rop_logic_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The operation register holds encoding 3 (copy source) and blending is enabled.
- R2: The operation field is bits 3:0 of the register at configuration address 0. With blending off, encodings 0 to 7 give the following results per channel:
  - 0: 0x00
  - 1: src AND dst
  - 2: src AND NOT dst
  - 3: src
  - 4: 0xFF
  - 5: NOT src
  - 6: dst
  - 7: NOT dst
- R3: With blending off, encodings 8 to 15 give the following results per channel:
  - 8: NOT(src AND dst)
  - 9: src OR dst
  - 10: NOT(src OR dst)
  - 11: src XOR dst
  - 12: NOT(src XOR dst)
  - 13: NOT src AND dst
  - 14: src OR NOT dst
  - 15: NOT src OR dst
- R4: Encoding 0 gives 0x00 and encoding 4 gives 0xFF in every channel, whatever the source and destination values.
- R5: The operation is applied to each of the four 8-bit channels separately. Channel k occupies bits 8k+7:8k, with R in bits 7:0 and A in bits 31:24. No bit of one channel affects another channel.
- R6: Bit 0 of the register at configuration address 1 is the blending enable (1 = on). When it is 1, `out_rgba` equals `in_blend`. When it is 0, `out_rgba` is the logic-operation result.
- R7: A pixel accepted at a rising edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` high after that same edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output pixel is held unchanged. When `out_ready` returns, a waiting input pixel is accepted at the same edge that drains the output.
- R9: A configuration write applies to pixels accepted at later edges. A pixel accepted at the same edge as the write still uses the previous configuration.
- R10: A write to any configuration address other than 0 or 1 changes neither register. Bits 3:1 of a blending-enable write are ignored.
- R11: `out_x` and `out_y` equal the coordinates of the pixel that is being output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 = operation, 1 = blending enable |
| cfg_wdata | input | 4 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Unit can accept a pixel |
| in_src | input | 32 | Fragment (source) RGBA |
| in_dst | input | 32 | Framebuffer (destination) RGBA |
| in_blend | input | 32 | Blend-unit result for this pixel |
| in_x | input | 11 | Pixel x coordinate |
| in_y | input | 11 | Pixel y coordinate |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgba | output | 32 | Merged RGBA |
| out_x | output | 11 | Output x coordinate |
| out_y | output | 11 | Output y coordinate |

## Verification
The bench drives a pixel on a falling edge, and the pixel is accepted at the next rising edge. The merged colour and the coordinates are due right after that edge, and the bench samples them at the following falling edge. A configuration write lands at a rising edge, so the bench checks it through the first pixel accepted after that edge. It also sends one pixel at the same edge as a write, which must still see the old setting. During backpressure the bench samples the stalled output over several falling edges. It then checks that the queued pixel appears one edge after `out_ready` rises.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic [3:0] {
        ROP_CLEAR    = 4'd0,
        ROP_AND      = 4'd1,
        ROP_AND_NDST = 4'd2,
        ROP_COPY     = 4'd3,
        ROP_SET      = 4'd4,
        ROP_NSRC     = 4'd5,
        ROP_KEEP     = 4'd6,
        ROP_NDST     = 4'd7,
        ROP_NAND     = 4'd8,
        ROP_OR       = 4'd9,
        ROP_NOR      = 4'd10,
        ROP_XOR      = 4'd11,
        ROP_XNOR     = 4'd12,
        ROP_NSRC_AND = 4'd13,
        ROP_SRC_ORN  = 4'd14,
        ROP_NSRC_OR  = 4'd15
    } rop_op_e;

    localparam int unsigned CFG_OP_ADDR    = 0;
    localparam int unsigned CFG_BLEND_ADDR = 1;

endpackage

// File: rtl/rop_cfg_regs.sv
module rop_cfg_regs
    import rop_pkg::*;
#(
    parameter int unsigned AW = 2,
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output rop_op_e       op_o,
    output logic          blend_en_o
);

    typedef struct packed {
        rop_op_e op;
        logic    blend_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == AW'(CFG_OP_ADDR)) begin
                cfg_d.op = rop_op_e'(wdata[3:0]);
            end else if (addr == AW'(CFG_BLEND_ADDR)) begin
                cfg_d.blend_en = wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.op       <= ROP_COPY;
            cfg_q.blend_en <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign op_o       = cfg_q.op;
    assign blend_en_o = cfg_q.blend_en;

    // R10
    stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr != AW'(CFG_OP_ADDR) && addr != AW'(CFG_BLEND_ADDR))
        |=> ($stable(op_o) && $stable(blend_en_o)));

endmodule

// File: rtl/rop_channel_op.sv
module rop_channel_op
    import rop_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic [CW-1:0] src,
    input  logic [CW-1:0] dst,
    input  rop_op_e       op,
    output logic [CW-1:0] res
);

    always_comb begin
        unique case (op)
            ROP_CLEAR:    res = '0;
            ROP_AND:      res = src & dst;
            ROP_AND_NDST: res = src & ~dst;
            ROP_COPY:     res = src;
            ROP_SET:      res = '1;
            ROP_NSRC:     res = ~src;
            ROP_KEEP:     res = dst;
            ROP_NDST:     res = ~dst;
            ROP_NAND:     res = ~(src & dst);
            ROP_OR:       res = src | dst;
            ROP_NOR:      res = ~(src | dst);
            ROP_XOR:      res = src ^ dst;
            ROP_XNOR:     res = ~(src ^ dst);
            ROP_NSRC_AND: res = ~src & dst;
            ROP_SRC_ORN:  res = src | ~dst;
            ROP_NSRC_OR:  res = ~src | dst;
            default:      res = src;
        endcase
    end

endmodule

// File: rtl/rop_logic_unit.sv
module rop_logic_unit
    import rop_pkg::*;
#(
    parameter int unsigned CH_W   = 8,
    parameter int unsigned N_CH   = 4,
    parameter int unsigned X_W    = 11,
    parameter int unsigned Y_W    = 11,
    parameter int unsigned CFG_AW = 2,
    parameter int unsigned CFG_DW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [CH_W*N_CH-1:0]   in_src,
    input  logic [CH_W*N_CH-1:0]   in_dst,
    input  logic [CH_W*N_CH-1:0]   in_blend,
    input  logic [X_W-1:0]         in_x,
    input  logic [Y_W-1:0]         in_y,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [CH_W*N_CH-1:0]   out_rgba,
    output logic [X_W-1:0]         out_x,
    output logic [Y_W-1:0]         out_y
);

    localparam int unsigned PIX_W = CH_W * N_CH;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] rgba;
        logic [X_W-1:0]   x;
        logic [Y_W-1:0]   y;
    } stage_t;

    rop_op_e          op;
    logic             blend_en;
    logic [PIX_W-1:0] logic_res;
    logic [PIX_W-1:0] merged;
    logic             accept;
    stage_t           pipe_d, pipe_q;

    rop_cfg_regs #(.AW(CFG_AW), .DW(CFG_DW)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .op_o       (op),
        .blend_en_o (blend_en)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        rop_channel_op #(.CW(CH_W)) chan_i (
            .src (in_src[c*CH_W +: CH_W]),
            .dst (in_dst[c*CH_W +: CH_W]),
            .op  (op),
            .res (logic_res[c*CH_W +: CH_W])
        );
    end

    assign merged   = blend_en ? in_blend : logic_res;
    assign in_ready = !pipe_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (out_ready) begin
            pipe_d.valid = 1'b0;
        end
        if (accept) begin
            pipe_d.valid = 1'b1;
            pipe_d.rgba  = merged;
            pipe_d.x     = in_x;
            pipe_d.y     = in_y;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.valid;
    assign out_rgba  = pipe_q.rgba;
    assign out_x     = pipe_q.x;
    assign out_y     = pipe_q.y;

    // R7
    accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_rgba) && $stable(out_x) && $stable(out_y)));

    // R11
    coord_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_x == $past(in_x) && out_y == $past(in_y)));

    // R6
    blend_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && blend_en) |=> (out_rgba == $past(in_blend)));

    // R4
    set_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !blend_en && op == ROP_SET) |=> (out_rgba == '1));

endmodule

// File: tb/rop_logic_unit_tb_top.sv
module rop_logic_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [3:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_src = '0, in_dst = '0, in_blend = '0;
    logic [10:0] in_x = '0, in_y = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_rgba;
    logic [10:0] out_x, out_y;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rop_logic_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_dst(in_dst), .in_blend(in_blend),
        .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
        .out_ready(out_ready), .out_rgba(out_rgba), .out_x(out_x), .out_y(out_y)
    );

    function automatic logic [7:0] exp_ch(input logic [3:0] op, input logic [7:0] s, input logic [7:0] d);
        case (op)
            4'd0:  return 8'h00;
            4'd1:  return s & d;
            4'd2:  return s & ~d;
            4'd3:  return s;
            4'd4:  return 8'hFF;
            4'd5:  return ~s;
            4'd6:  return d;
            4'd7:  return ~d;
            4'd8:  return ~(s & d);
            4'd9:  return s | d;
            4'd10: return ~(s | d);
            4'd11: return s ^ d;
            4'd12: return ~(s ^ d);
            4'd13: return ~s & d;
            4'd14: return s | ~d;
            default: return ~s | d;
        endcase
    endfunction

    function automatic logic [31:0] exp_pix(input logic [3:0] op, input logic [31:0] s, input logic [31:0] d);
        logic [31:0] r;
        for (int c = 0; c < 4; c++) r[c*8 +: 8] = exp_ch(op, s[c*8 +: 8], d[c*8 +: 8]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_pix(input logic [31:0] s, input logic [31:0] d, input logic [31:0] b,
                             input logic [10:0] x, input logic [10:0] y);
        in_valid = 1'b1; in_src = s; in_dst = d; in_blend = b; in_x = x; in_y = y;
    endtask

    // drive at a falling edge, accepted at the next rising edge, checked at the following falling edge
    task automatic send(input string req, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] b, input logic [31:0] exp);
        @(negedge clk);
        drive_pix(s, d, b, 11'(checks), 11'(checks + 7));
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {31'd0, out_valid}, 32'd1);
        check(req, out_rgba, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] s, d, b;
        logic [3:0]  op;
        logic        ben;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        // R1 default blending on, then default copy
        send("R1 default blend", 32'h11223344, 32'h55667788, 32'hCAFEF00D, 32'hCAFEF00D);
        cfg_write(2'd1, 4'd0);
        send("R1 default copy", 32'h11223344, 32'h55667788, 32'hCAFEF00D, 32'h11223344);

        // R2 / R3 every encoding on a pattern exercising all bit combinations
        for (int e = 0; e < 16; e++) begin
            cfg_write(2'd0, 4'(e));
            send(e < 8 ? "R2 encoding" : "R3 encoding", 32'hF0CC_AA0F, 32'hFF00_F0CC,
                 32'h0, exp_pix(4'(e), 32'hF0CC_AA0F, 32'hFF00_F0CC));
        end

        // R4 clear / set independent of data
        cfg_write(2'd0, 4'd0);
        send("R4 clear", 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678, 32'h00000000);
        cfg_write(2'd0, 4'd4);
        send("R4 set", 32'h00000000, 32'h00000000, 32'h12345678, 32'hFFFFFFFF);

        // R5 distinct channels: XOR with per-channel distinct data
        cfg_write(2'd0, 4'd11);
        send("R5 channels", 32'h01_02_04_08, 32'h80_40_20_10, 32'h0, 32'h81_42_24_18);

        // R6 blending on passes blend input
        cfg_write(2'd1, 4'd1);
        send("R6 blend on", 32'h01_02_04_08, 32'h80_40_20_10, 32'hDEADBEEF, 32'hDEADBEEF);
        // R10 blending write ignores bits 3:1
        cfg_write(2'd1, 4'b1110);
        send("R10 blend bits", 32'h01_02_04_08, 32'h80_40_20_10, 32'hDEADBEEF, 32'h81_42_24_18);
        // R10 stray addresses ignored
        cfg_write(2'd2, 4'd1);
        cfg_write(2'd3, 4'd1);
        send("R10 stray addr", 32'h01_02_04_08, 32'h80_40_20_10, 32'hDEADBEEF, 32'h81_42_24_18);

        // R9 same-edge write uses old op (XOR), next pixel uses new (copy)
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 4'd3;
        drive_pix(32'hA5A5A5A5, 32'h0F0F0F0F, 32'h0, 11'd100, 11'd200);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        check("R9 same edge old cfg", out_rgba, 32'hAAAAAAAA);
        check("R11 out_x", {21'd0, out_x}, 32'd100);
        check("R11 out_y", {21'd0, out_y}, 32'd200);
        send("R9 next pixel new cfg", 32'hA5A5A5A5, 32'h0F0F0F0F, 32'h0, 32'hA5A5A5A5);

        // R8 backpressure
        cfg_write(2'd0, 4'd9);
        @(negedge clk);
        out_ready = 1'b0;
        drive_pix(32'h01010101, 32'h10101010, 32'h0, 11'd5, 11'd6);
        @(negedge clk);
        drive_pix(32'h02020202, 32'h20202020, 32'h0, 11'd7, 11'd8);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 stall valid", {31'd0, out_valid}, 32'd1);
            check("R8 stall ready", {31'd0, in_ready}, 32'd0);
            check("R8 stall data", out_rgba, 32'h11111111);
            check("R11 stall x", {21'd0, out_x}, 32'd5);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 queued valid", {31'd0, out_valid}, 32'd1);
        check("R8 queued data", out_rgba, 32'h22222222);
        check("R11 queued y", {21'd0, out_y}, 32'd8);
        @(negedge clk);
        // R7 output drains when nothing new is accepted
        check("R7 drained", {31'd0, out_valid}, 32'd0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            op = 4'($urandom_range(0, 15));
            ben = ($urandom_range(0, 3) == 0);
            s = $urandom; d = $urandom; b = $urandom;
            cfg_write(2'd0, op);
            cfg_write(2'd1, {3'($urandom_range(0, 7)), ben});
            send(op < 8 ? "R2 random" : "R3 random", s, d, b, ben ? b : exp_pix(op, s, d));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule